// File: doc/BRIEF.md
# Cartridge Bank Mapping Register Unit

This block maps memory banks for an 8-bit console cartridge. It watches CPU writes to the upper half of the CPU address space and decodes them by a coarse address match into eight sparse register slots. Four slots hold the bank numbers of the 2 KiB pattern-memory windows. One slot holds the switchable 16 KiB program window. One slot holds a two-bit nametable arrangement code. The remaining two slots belong to a separate interval-counter block, which receives a one-cycle write strobe from this unit for each of them.

The unit translates addresses combinationally. The lower CPU program window at $8000-$BFFF comes from the program bank register. The upper window at $C000-$FFFF is pinned to the highest bank that the configured ROM size allows. Pattern addresses from the picture processor take their bank from one of four registers, chosen by address bits 12..11. The VRAM A10 line is driven according to the arrangement code, so that the nametable layout can be vertical, horizontal or single-screen.

Top module: `cart_bank_mapper`

## Requirements
- R1: A synchronous reset clears every bank register and the arrangement code to zero. After reset, program window 0 reads bank 0, every pattern window reads bank 0, and VRAM A10 follows PPU A10.
- R2: A write hits a slot only when cpu_wr is 1, A15 is 1 and A11 is 1. A14..A12 pick the slot. The values 0, 1, 2 and 3 load the pattern bank for PPU $0000, $0800, $1000 and $1800, so $BFFF also loads the $1800 bank. The pattern ROM address is {bank of window ppu_addr[12:11], ppu_addr[10:0]}.
- R3: Slot 7 (for example $F800) loads the program bank from the data bus. When CPU A14 is 0, prg_addr is {program bank, cpu_addr[13:0]}.
- R4: When CPU A14 is 1, prg_addr is {all ones of PRG_BANK_W bits, cpu_addr[13:0]}, whatever has been written.
- R5: Slot 6 (for example $E800) loads the arrangement code from data bits 1..0. Codes 0, 1, 2 and 3 drive vram_a10 from PPU A10, from PPU A11, as constant 0 and as constant 1.
- R6: No register changes when cpu_wr is 0, when A15 is 0 (for example $7800) or when A11 is 0 (for example $8000 or $F000).
- R7: During a decoded write, irq_load_wr is 1 for slot 4 (for example $C800) and irq_ctrl_wr is 1 for slot 5 (for example $D800), in the same cycle as the write. Neither strobe is 1 at any other time, and neither slot changes a bank register or the arrangement code.
- R8: A register write shows at the address outputs from the clock edge on which the strobe is sampled.
- R9: Data bits 7..2 of an arrangement write have no effect: a write of $FE selects code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | PPU address bits A12..A0 |
| prg_addr | output | PRG_BANK_W+14 | Program ROM address |
| chr_addr | output | CHR_BANK_W+11 | Pattern ROM address |
| vram_a10 | output | 1 | Nametable VRAM A10 |
| irq_load_wr | output | 1 | Counter-load slot write strobe |
| irq_ctrl_wr | output | 1 | Counter-control slot write strobe |

## Verification
The two counter strobes are combinational, so they are due in the same cycle that the write is presented. The bench samples them 1 ns after driving the inputs and before the clock edge. A bank or arrangement write is registered once, so its effect on prg_addr, chr_addr and vram_a10 is due after exactly one rising edge. The bench drops the strobe and probes each window on the following falling edge. Those probe addresses are combinational paths as well, so each probe is sampled 1 ns after it is driven, with cpu_wr held low so that no probe can write.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    // Register slot chosen by CPU A14..A12 when A15 and A11 are both set
    typedef enum logic [2:0] {
        SLOT_CHR0  = 3'd0,
        SLOT_CHR1  = 3'd1,
        SLOT_CHR2  = 3'd2,
        SLOT_CHR3  = 3'd3,
        SLOT_CNT_LD = 3'd4,
        SLOT_CNT_CT = 3'd5,
        SLOT_ARRNG = 3'd6,
        SLOT_PRG   = 3'd7
    } slot_e;

    // Nametable arrangement codes
    typedef enum logic [1:0] {
        ARR_VERT  = 2'd0,
        ARR_HORZ  = 2'd1,
        ARR_LOW   = 2'd2,
        ARR_HIGH  = 2'd3
    } arrange_e;

    localparam int unsigned NUM_CHR_WIN = 4;

endpackage

// File: rtl/cbm_reg_file.sv
module cbm_reg_file
    import cbm_pkg::*;
#(
    parameter int unsigned PRG_BANK_W = 8,
    parameter int unsigned CHR_BANK_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [15:0]                             cpu_addr,
    input  logic [7:0]                              cpu_data,
    input  logic                                    cpu_wr,
    output logic [NUM_CHR_WIN-1:0][CHR_BANK_W-1:0]  chr_bank,
    output logic [PRG_BANK_W-1:0]                   prg_bank,
    output arrange_e                                arrange,
    output logic                                    irq_load_wr,
    output logic                                    irq_ctrl_wr
);

    typedef struct packed {
        logic [NUM_CHR_WIN-1:0][CHR_BANK_W-1:0] chr;
        logic [PRG_BANK_W-1:0]                  prg;
        arrange_e                               arr;
    } bank_regs_t;

    bank_regs_t regs_d, regs_q;
    logic       hit;
    slot_e      slot;

    assign hit  = cpu_wr && cpu_addr[15] && cpu_addr[11];
    assign slot = slot_e'(cpu_addr[14:12]);

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else if (hit) begin
            case (slot)
                SLOT_CHR0, SLOT_CHR1, SLOT_CHR2, SLOT_CHR3:
                    regs_d.chr[cpu_addr[13:12]] = cpu_data[CHR_BANK_W-1:0];
                SLOT_ARRNG:
                    regs_d.arr = arrange_e'(cpu_data[1:0]);
                SLOT_PRG:
                    regs_d.prg = cpu_data[PRG_BANK_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign chr_bank    = regs_q.chr;
    assign prg_bank    = regs_q.prg;
    assign arrange     = regs_q.arr;
    assign irq_load_wr = hit && (slot == SLOT_CNT_LD);
    assign irq_ctrl_wr = hit && (slot == SLOT_CNT_CT);

    // R1: registers are zero right after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chr_bank == '0 && prg_bank == '0 && arrange == ARR_VERT));

    // R2: pattern slot write lands in the addressed window
    p_chr_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15] && cpu_addr[11] && !cpu_addr[14])
        |=> chr_bank[$past(cpu_addr[13:12])] == $past(cpu_data[CHR_BANK_W-1:0]));

    // R3: program slot write loads the program bank
    p_prg_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:11] == 5'b11111)
        |=> prg_bank == $past(cpu_data[PRG_BANK_W-1:0]));

    // R6: no decoded write, no register change
    p_no_write_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr[15] && cpu_addr[11])
        |=> ($stable(chr_bank) && $stable(prg_bank) && $stable(arrange)));

    // R7: the two counter strobes are never both active
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_load_wr, irq_ctrl_wr}));

    // R9: arrangement write keeps only data bits 1..0
    p_arr_low_bits_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:11] == 5'b11101)
        |=> arrange == arrange_e'($past(cpu_data[1:0])));

endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
    parameter int unsigned PRG_BANK_W = 8,
    localparam int unsigned PRG_AW = PRG_BANK_W + 14
) (
    input  logic [PRG_BANK_W-1:0] prg_bank,
    input  logic [14:0]           cpu_off,
    output logic [PRG_AW-1:0]     prg_addr
);

    localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;

    logic [PRG_BANK_W-1:0] bank_sel;

    always_comb begin
        bank_sel = cpu_off[14] ? LAST_BANK : prg_bank;
        prg_addr = {bank_sel, cpu_off[13:0]};
    end

    // R4: the upper window always lands in the highest bank
    always_comb begin
        if (cpu_off[14] === 1'b1) begin
            p_fixed_last_r4: assert (&prg_addr[PRG_AW-1:14]);
        end
    end

endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
    import cbm_pkg::*;
#(
    parameter int unsigned CHR_BANK_W = 8,
    localparam int unsigned CHR_AW = CHR_BANK_W + 11
) (
    input  logic [NUM_CHR_WIN-1:0][CHR_BANK_W-1:0] chr_bank,
    input  logic [12:0]                            ppu_addr,
    output logic [CHR_AW-1:0]                      chr_addr
);

    logic [CHR_BANK_W-1:0] win_bank;

    always_comb begin
        win_bank = '0;
        for (int w = 0; w < NUM_CHR_WIN; w++) begin
            if (ppu_addr[12:11] == w[1:0]) win_bank = chr_bank[w];
        end
        chr_addr = {win_bank, ppu_addr[10:0]};
    end

endmodule

// File: rtl/cbm_vram_sel.sv
module cbm_vram_sel
    import cbm_pkg::*;
(
    input  arrange_e    arrange,
    input  logic [1:0]  ppu_a11_a10,
    output logic        vram_a10
);

    always_comb begin
        case (arrange)
            ARR_VERT: vram_a10 = ppu_a11_a10[0];
            ARR_HORZ: vram_a10 = ppu_a11_a10[1];
            ARR_LOW:  vram_a10 = 1'b0;
            default:  vram_a10 = 1'b1;
        endcase
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int unsigned PRG_BANK_W = 8,
    parameter int unsigned CHR_BANK_W = 8,
    localparam int unsigned PRG_AW = PRG_BANK_W + 14,
    localparam int unsigned CHR_AW = CHR_BANK_W + 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              vram_a10,
    output logic              irq_load_wr,
    output logic              irq_ctrl_wr
);

    logic [NUM_CHR_WIN-1:0][CHR_BANK_W-1:0] chr_bank;
    logic [PRG_BANK_W-1:0]                  prg_bank;
    arrange_e                               arrange;

    cbm_reg_file #(
        .PRG_BANK_W(PRG_BANK_W),
        .CHR_BANK_W(CHR_BANK_W)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_wr     (cpu_wr),
        .chr_bank   (chr_bank),
        .prg_bank   (prg_bank),
        .arrange    (arrange),
        .irq_load_wr(irq_load_wr),
        .irq_ctrl_wr(irq_ctrl_wr)
    );

    cbm_prg_map #(.PRG_BANK_W(PRG_BANK_W)) prg_i (
        .prg_bank(prg_bank),
        .cpu_off (cpu_addr[14:0]),
        .prg_addr(prg_addr)
    );

    cbm_chr_map #(.CHR_BANK_W(CHR_BANK_W)) chr_i (
        .chr_bank(chr_bank),
        .ppu_addr(ppu_addr),
        .chr_addr(chr_addr)
    );

    cbm_vram_sel vram_i (
        .arrange    (arrange),
        .ppu_a11_a10(ppu_addr[11:10]),
        .vram_a10   (vram_a10)
    );

endmodule

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = 13'h0000;
    logic [21:0] prg_addr;
    logic [18:0] chr_addr;
    logic        vram_a10;
    logic        irq_load_wr;
    logic        irq_ctrl_wr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_chr [4];
    logic [7:0] m_prg;
    logic [1:0] m_arr;

    always #2 clk = ~clk;

    cart_bank_mapper dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .vram_a10(vram_a10),
        .irq_load_wr(irq_load_wr), .irq_ctrl_wr(irq_ctrl_wr)
    );

    // {address, data}
    localparam int NV = 15;
    localparam logic [23:0] VEC [NV] = '{
        {16'h8800, 8'h05}, {16'h9800, 8'h1A}, {16'hA800, 8'hC3},
        {16'hBFFF, 8'h7E}, {16'hF800, 8'h42}, {16'h8000, 8'h99},
        {16'h7800, 8'h55}, {16'hE800, 8'h01}, {16'hE800, 8'hFE},
        {16'hEFFF, 8'h03}, {16'hC800, 8'h12}, {16'hD800, 8'h10},
        {16'hF000, 8'h11}, {16'hE800, 8'h00}, {16'hFFFF, 8'hFF}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic exp_a10(input logic [1:0] mode, input logic [12:0] pa);
        case (mode)
            2'd0: return pa[10];
            2'd1: return pa[11];
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Model update from requirements R2, R3, R5, R6, R9
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15] && a[11]) begin
            case (a[14:12])
                3'd0, 3'd1, 3'd2, 3'd3: m_chr[a[13:12]] = d;
                3'd6: m_arr = d[1:0];
                3'd7: m_prg = d;
                default: ;
            endcase
        end
    endtask

    task automatic probe_all();
        cpu_wr = 1'b0;
        cpu_addr = 16'h8123;
        #1 check("R3 low window", 32'(prg_addr), 32'({m_prg, 14'h0123}));
        cpu_addr = 16'hF456;
        #1 check("R4 fixed window", 32'(prg_addr), 32'({8'hFF, 14'h3456}));
        for (int w = 0; w < 4; w++) begin
            ppu_addr = {w[1:0], 11'h2A5};
            #1 check("R2 pattern window", 32'(chr_addr), 32'({m_chr[w], 11'h2A5}));
        end
        ppu_addr = 13'h0400;
        #1 check("R5 a10 probe", 32'(vram_a10), 32'(exp_a10(m_arr, 13'h0400)));
        ppu_addr = 13'h0800;
        #1 check("R5 a11 probe", 32'(vram_a10), 32'(exp_a10(m_arr, 13'h0800)));
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic wr);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = wr;
        #1;
        check("R7 load strobe", 32'(irq_load_wr),
              32'(wr && a[15] && a[11] && a[14:12] == 3'd4));
        check("R7 ctrl strobe", 32'(irq_ctrl_wr),
              32'(wr && a[15] && a[11] && a[14:12] == 3'd5));
        if (wr) model_write(a, d);
        @(negedge clk);
        cpu_wr = 1'b0;
        probe_all(); // R8: effect due one edge after the write
    endtask

    initial begin
        for (int w = 0; w < 4; w++) m_chr[w] = 8'h00;
        m_prg = 8'h00; m_arr = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        probe_all(); // R1 reset state
        check("R1 reset prg", 32'(prg_addr[21:14]), 32'hFF);
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][23:8], VEC[i][7:0], 1'b1);
        end
        // R9: upper data bits ignored on arrangement write
        do_write(16'hE800, 8'hFE, 1'b1);
        check("R9 mode from FE", 32'(vram_a10), 32'd0);
        // R6: strobe low does not write
        do_write(16'hF800, 8'h3C, 1'b0);
        check("R6 wr low prg", 32'(prg_addr), 32'({8'hFF, 14'h3456}));
        cpu_addr = 16'h8000;
        #1 check("R6 wr low keep", 32'(prg_addr[21:14]), 32'hFF);
        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < 4; w++) m_chr[w] = 8'h00;
        m_prg = 8'h00; m_arr = 2'd0;
        probe_all();
        ppu_addr = 13'h0C00;
        #1 check("R1 a10 after reset", 32'(vram_a10), 32'd1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule